// File: doc/BRIEF.md
# Audio output lock supervisor with soft mute

This block sits at the output end of a sample-rate converter and decides what reaches the output sample stream. It reports an active-high unlock status taken from the power-down pin and an internal lock flag. Each parallel sample word arrives with a one-cycle strobe and is passed through, attenuated or replaced by zero, depending on the lock state, the activity of the output-side clock and a soft-mute request.

The output clock is watched from the reference clock domain. When it goes quiet for a set number of reference cycles, the block drops into an internal reset: output words go to zero, qualification starts over and the gain returns to full attenuation. No power-down is needed for this. After lock returns, the block counts a set number of strobes with zero output before data is let through. The data then comes back through a gain ramp rather than as a step. The soft-mute ramp and its release each take one step per passing sample strobe, 2^RAMP_LOG2 steps in all (1024 by default). A new request in the middle of a ramp turns it around from the present gain.

Top module: `outlock_guard`

## Requirements
- R1: While `pwr_up` is high, `unlock_o` equals the inverse of `lock_in` in the same cycle.
- R2: A strobe taken while `lock_in` is low yields an output word of zero, whatever `smp_in` holds, and clears qualification and gain.
- R3: While `pwr_up` is low, `unlock_o` is high. At the next clock edge `smp_vld` and `smp_out` are zero, qualification is cleared and the gain is at full attenuation (gain 0).
- R4: If the output clock `oclk` shows no rising edge for STOP_CYC reference cycles, the block resets itself internally with `pwr_up` still high. While it is in that state, every strobe gives zero and qualification and gain are cleared.
- R5: Once lock is present and the output clock is running, the first QUAL_STB strobes give zero. Strobe QUAL_STB+1 is the first one that passes data.
- R6: A passing strobe gives floor(x*g / 2^RAMP_LOG2), taken as SMP_W-bit two's complement, where x is the signed `smp_in` and g is the gain before that strobe (0 to 2^RAMP_LOG2). At g = 2^RAMP_LOG2 the output equals the input exactly.
- R7: On each passing strobe the gain steps by exactly one. It steps down toward 0 while `mute_req` is high and up toward 2^RAMP_LOG2 while it is low, and stops at either end. A change of request in the middle of a ramp reverses from the current value.
- R8: After the output clock restarts with lock held, full-gain data is delivered at strobe QUAL_STB+1+2^RAMP_LOG2, which bounds the recovery time.
- R9: `smp_vld` is high exactly one cycle after each `smp_stb`, and `smp_out` is registered on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pwr_up | input | 1 | Low = power-down, synchronous reset of all state |
| lock_in | input | 1 | Internal lock flag, high when locked |
| oclk | input | 1 | Output-side clock, asynchronous, watched for activity |
| mute_req | input | 1 | Soft-mute request, high = ramp to full attenuation |
| smp_in | input | SMP_W | Signed input sample word |
| smp_stb | input | 1 | One-cycle strobe marking a new input sample |
| smp_out | output | SMP_W | Signed output sample word after gating and gain |
| smp_vld | output | 1 | High for one cycle when `smp_out` holds a new word |
| unlock_o | output | 1 | High while unlocked or powered down |

## Verification
The bench builds the block with RAMP_LOG2 = 4, QUAL_STB = 3 and STOP_CYC = 20. A complete ramp therefore takes 16 strobes, and the recovery path after a clock stop fits inside a few dozen samples. With these values a single run can cover a full mute and a full release, a reversal in the middle of a ramp, exact pass-through at unity gain for the extreme sample values, and the timeout of the clock watcher after an output clock that runs at one rising edge per six reference cycles. The defaults (1024 steps, 256-cycle timeout) differ only in counter widths.

// File: rtl/olg_pkg.sv
package olg_pkg;

  // One ramp step toward 0 (down=1) or toward top (down=0), saturating.
  function automatic int unsigned next_gain(int unsigned cur, logic down, int unsigned top);
    if (down) return (cur == 0) ? 0 : cur - 1;
    else      return (cur >= top) ? top : cur + 1;
  endfunction

endpackage

// File: rtl/olg_clk_watch.sv
module olg_clk_watch #(
  parameter int STOP_CYC = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oclk,
  output logic stopped
);
  localparam int CW = $clog2(STOP_CYC + 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] idle_q;
  logic          edge_w;

  assign edge_w  = sync_q[1] & ~sync_q[2];
  assign stopped = (idle_q == CW'(STOP_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      idle_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], oclk};
      if (edge_w)        idle_q <= '0;
      else if (!stopped) idle_q <= idle_q + 1'b1;
    end
  end
endmodule

// File: rtl/olg_qualify.sv
module olg_qualify #(
  parameter int QUAL_STB = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic stb,
  output logic ready
);
  localparam int QW = $clog2(QUAL_STB + 1);

  logic [QW-1:0] cnt_q;

  assign ready = (cnt_q == QW'(QUAL_STB));

  always_ff @(posedge clk) begin
    if (!rst_n || hold)     cnt_q <= '0;
    else if (stb && !ready) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/olg_gain.sv
module olg_gain #(
  parameter int SMP_W     = 24,
  parameter int RAMP_LOG2 = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             adv,
  input  logic             mute,
  input  logic [SMP_W-1:0] din,
  output logic [SMP_W-1:0] dout,
  output logic [RAMP_LOG2:0] gain
);
  localparam int GW    = RAMP_LOG2 + 1;
  localparam int UNITY = 1 << RAMP_LOG2;

  function automatic logic [SMP_W-1:0] scale(logic [SMP_W-1:0] x, logic [GW-1:0] g);
    logic signed [SMP_W+GW:0] p;
    p = $signed(x) * $signed({1'b0, g});
    return SMP_W'(p >>> RAMP_LOG2);
  endfunction

  logic [GW-1:0] gain_q;

  assign gain = gain_q;
  assign dout = scale(din, gain_q);

  always_ff @(posedge clk) begin
    if (!rst_n || hold) gain_q <= '0;
    else if (adv)       gain_q <= GW'(olg_pkg::next_gain(32'(gain_q), mute, UNITY));
  end
endmodule

// File: rtl/outlock_guard.sv
module outlock_guard #(
  parameter int SMP_W     = 24,
  parameter int RAMP_LOG2 = 10,
  parameter int QUAL_STB  = 8,
  parameter int STOP_CYC  = 256
) (
  input  logic             clk,
  input  logic             pwr_up,
  input  logic             lock_in,
  input  logic             oclk,
  input  logic             mute_req,
  input  logic [SMP_W-1:0] smp_in,
  input  logic             smp_stb,
  output logic [SMP_W-1:0] smp_out,
  output logic             smp_vld,
  output logic             unlock_o
);
  // Named internal events, observed by the bound checker.
  logic             stop_w;
  logic             hold_w;
  logic             ready_w;
  logic             pass_w;
  logic [SMP_W-1:0] scaled_w;
  logic [RAMP_LOG2:0] gain_w;

  assign hold_w   = !lock_in || stop_w;
  assign pass_w   = ready_w && !hold_w;
  assign unlock_o = !pwr_up || !lock_in;

  olg_clk_watch #(.STOP_CYC(STOP_CYC)) u_watch (
    .clk(clk), .rst_n(pwr_up), .oclk(oclk), .stopped(stop_w)
  );

  olg_qualify #(.QUAL_STB(QUAL_STB)) u_qual (
    .clk(clk), .rst_n(pwr_up), .hold(hold_w), .stb(smp_stb), .ready(ready_w)
  );

  olg_gain #(.SMP_W(SMP_W), .RAMP_LOG2(RAMP_LOG2)) u_gain (
    .clk(clk), .rst_n(pwr_up), .hold(hold_w), .adv(smp_stb && pass_w),
    .mute(mute_req), .din(smp_in), .dout(scaled_w), .gain(gain_w)
  );

  always_ff @(posedge clk) begin
    if (!pwr_up) begin
      smp_out <= '0;
      smp_vld <= 1'b0;
    end else begin
      smp_vld <= smp_stb;
      if (smp_stb) smp_out <= pass_w ? scaled_w : '0;
    end
  end
endmodule

// File: rtl/outlock_guard_chk.sv
module outlock_guard_chk #(
  parameter int SMP_W     = 24,
  parameter int RAMP_LOG2 = 10
) (
  input logic             clk,
  input logic             pwr_up,
  input logic             lock_in,
  input logic             smp_stb,
  input logic [SMP_W-1:0] smp_out,
  input logic             smp_vld,
  input logic             unlock_o,
  input logic             stop_w,
  input logic             ready_w,
  input logic [RAMP_LOG2:0] gain_w
);
  localparam int UNITY = 1 << RAMP_LOG2;

  a_r1_unlock_follows_lock: assert property (@(posedge clk)
    pwr_up |-> (unlock_o == !lock_in));

  a_r2_zero_when_unlocked: assert property (@(posedge clk) disable iff (!pwr_up)
    (smp_stb && !lock_in) |=> (smp_out == '0));

  a_r3_pd_flags_unlock: assert property (@(posedge clk)
    !pwr_up |-> unlock_o);

  a_r3_pd_clears_valid: assert property (@(posedge clk)
    !pwr_up |=> (!smp_vld && smp_out == '0));

  a_r4_zero_when_stopped: assert property (@(posedge clk) disable iff (!pwr_up)
    (smp_stb && stop_w) |=> (smp_out == '0));

  a_r5_zero_while_qualifying: assert property (@(posedge clk) disable iff (!pwr_up)
    (smp_stb && !ready_w) |=> (smp_out == '0));

  a_r7_gain_single_step: assert property (@(posedge clk) disable iff (!pwr_up)
    ((gain_w != $past(gain_w)) && (gain_w != '0)) |->
      ((gain_w == $past(gain_w) + 1'b1) || (gain_w == $past(gain_w) - 1'b1)));

  a_r7_gain_in_range: assert property (@(posedge clk) disable iff (!pwr_up)
    (32'(gain_w) <= UNITY));

  a_r9_valid_follows_strobe: assert property (@(posedge clk) disable iff (!pwr_up)
    smp_stb |=> smp_vld);

  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!pwr_up)
    !smp_stb |=> !smp_vld);
endmodule

bind outlock_guard outlock_guard_chk #(.SMP_W(SMP_W), .RAMP_LOG2(RAMP_LOG2)) u_chk (
  .clk(clk), .pwr_up(pwr_up), .lock_in(lock_in), .smp_stb(smp_stb),
  .smp_out(smp_out), .smp_vld(smp_vld), .unlock_o(unlock_o),
  .stop_w(stop_w), .ready_w(ready_w), .gain_w(gain_w)
);

// File: tb/outlock_guard_tb.sv
`timescale 1ns/1ps
module outlock_guard_tb;
  localparam int W = 24;
  localparam int L = 4;
  localparam int Q = 3;
  localparam int S = 20;
  localparam int UNITY = 1 << L;

  logic clk = 1'b0;
  logic pwr_up = 1'b0, lock_in = 1'b0, oclk = 1'b0, mute_req = 1'b0, smp_stb = 1'b0;
  logic oclk_en = 1'b1;
  logic [W-1:0] smp_in = '0;
  logic [W-1:0] smp_out;
  logic smp_vld, unlock_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model state
  int mq = 0, mg = 0;
  bit mstop = 0;
  logic [W-1:0] expq[$];
  string tagq[$];

  always #2 clk = ~clk;
  initial begin
    #1;
    forever begin
      #12;
      if (oclk_en) oclk = ~oclk;
    end
  end

  outlock_guard #(.SMP_W(W), .RAMP_LOG2(L), .QUAL_STB(Q), .STOP_CYC(S)) u_dut (
    .clk(clk), .pwr_up(pwr_up), .lock_in(lock_in), .oclk(oclk), .mute_req(mute_req),
    .smp_in(smp_in), .smp_stb(smp_stb), .smp_out(smp_out), .smp_vld(smp_vld),
    .unlock_o(unlock_o)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    mq = 0;
    mg = 0;
  endtask

  // Driver: computes the expected word and pushes it to the scoreboard.
  task automatic send(int x, string req);
    longint p;
    logic [W-1:0] e;
    bit pass;
    @(negedge clk);
    pass = (mq == Q) && lock_in && !mstop;
    p = longint'(x) * longint'(mg);
    e = pass ? W'(p >>> L) : '0;
    expq.push_back(e);
    tagq.push_back(req);
    if (!lock_in || mstop) model_clear();
    else begin
      if (pass) begin
        if (mute_req) mg = (mg == 0) ? 0 : mg - 1;
        else          mg = (mg >= UNITY) ? UNITY : mg + 1;
      end
      if (mq < Q) mq++;
    end
    smp_in  = W'(x);
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  // Monitor: pops expected words as valid outputs appear.
  always @(negedge clk) begin
    if (pwr_up && smp_vld) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 actual=unexpected valid expected=none");
      end else begin
        logic [W-1:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(t, smp_out, e);
      end
    end
  end

  int vals[8] = '{8388607, -8388608, 1000, -1000, 4660, -1, 123457, -654321};

  initial begin
    repeat (5) @(negedge clk);
    // Reset state (R3)
    check("R3 unlock in power-down", W'(unlock_o), W'(1));
    check("R3 valid in power-down", W'(smp_vld), W'(0));
    check("R3 output in power-down", smp_out, '0);
    smp_stb = 1'b1; smp_in = 24'h123456;
    @(negedge clk); smp_stb = 1'b0;
    @(negedge clk);
    check("R3 strobe ignored in power-down", W'(smp_vld), W'(0));

    pwr_up = 1'b1;
    @(negedge clk);
    check("R1 unlock high without lock", W'(unlock_o), W'(1));
    send(5000, "R2 zero while unlocked");
    send(-7, "R2 zero while unlocked");
    lock_in = 1'b1;
    #1;
    check("R1 unlock low with lock", W'(unlock_o), W'(0));

    // Qualification (R5) then ramp-up (R6, R7)
    for (int i = 0; i < Q + 1; i++) send(77777, "R5 qualification");
    for (int i = 0; i < UNITY + 4; i++) send(vals[i % 8], "R6 ramp-up scaling");
    for (int i = 0; i < 8; i++) send(vals[i], "R6 unity pass-through");

    // Soft mute: partial, reversal, full
    mute_req = 1'b1;
    for (int i = 0; i < 6; i++) send(vals[(i + 3) % 8], "R7 mute ramp down");
    mute_req = 1'b0;
    for (int i = 0; i < 3; i++) send(vals[i], "R7 reversal mid-ramp");
    mute_req = 1'b1;
    for (int i = 0; i < UNITY + 3; i++) send(8388607, "R7 full attenuation");
    @(negedge clk);
    check("R7 muted output zero", smp_out, '0);
    mute_req = 1'b0;
    for (int i = 0; i < UNITY + 2; i++) send(vals[(i + 5) % 8], "R7 release ramp");

    // Lock loss (R2, R1)
    lock_in = 1'b0; model_clear();
    #1;
    check("R1 unlock on lock loss", W'(unlock_o), W'(1));
    send(8388607, "R2 zero on lock loss");
    send(-8388608, "R2 zero on lock loss");
    lock_in = 1'b1;
    for (int i = 0; i < Q + 3; i++) send(4096, "R5 requalify after lock");

    // Output clock stop (R4), then restart and recovery (R8)
    oclk_en = 1'b0;
    repeat (40) @(negedge clk);
    mstop = 1; model_clear();
    check("R4 lock unaffected by clock stop", W'(unlock_o), W'(0));
    send(8388607, "R4 zero with output clock stopped");
    send(-3, "R4 zero with output clock stopped");
    oclk_en = 1'b1;
    repeat (10) @(negedge clk);
    mstop = 0;
    for (int i = 0; i < Q + UNITY; i++) send(3000, "R8 recovery");
    send(-2468, "R8 recovery");
    check("R8 full gain at bound", smp_out, W'(-2468));

    // Power-down mid-run (R3)
    pwr_up = 1'b0;
    #1;
    check("R3 unlock on power-down", W'(unlock_o), W'(1));
    @(negedge clk);
    check("R3 output cleared", smp_out, '0);
    check("R3 valid cleared", W'(smp_vld), W'(0));
    expq.delete(); tagq.delete();
    model_clear();
    pwr_up = 1'b1;
    for (int i = 0; i < Q + 2; i++) send(9999, "R3 gain back at full attenuation");
    repeat (3) @(negedge clk);
    check("R9 scoreboard drained", W'(expq.size()), W'(0));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule